// File: doc/BRIEF.md
# Double-Buffered SPI Port

This block is a bus-mapped SPI port that runs either as the clock master or as a slave clocked from outside. One 16-bit shift register moves data out on `sdo` and in from `sdi` at the same time. A transmit holding word and a receive holding word sit at the same bus address. A write to that address fills the transmit side, and a read from it returns the receive side. Words are 8 or 16 bits long and go out most significant bit first.

When a word completes, the shift register contents move to the receive holding word. A pending transmit word then drops into the shift register. In master mode that load starts the next transfer at once, so writing the data address is all software needs to do to send. Each completion sets an interrupt flag. If the receive holding word was never read, the new word is dropped, an overflow flag is raised, and the shift engine freezes until software reads the data address.

The bus has three addresses: 0 is control, 1 is status and 2 is data. The control fields are:
- bits [2:0]: prescaler
- bit 3: 16-bit mode
- bit 4: clock idle level
- bit 5: master select
- bit 7: interrupt enable

The status bits are:
- bit 15: module enable (read/write)
- bit 8: interrupt flag
- bit 6: overflow
- bit 2: busy
- bit 1: transmit full
- bit 0: receive full

Top module: `spi_dbuf_ctrl`

## Requirements
- R1: After reset the control and status registers read 0, and `irq`, `sck_o` and `sck_oe` are low.
- R2: In master mode (control bit 5 = 1) with enable (status bit 15) set, a write to address 2 starts a transfer. The transfer lasts 8 clock periods, or 16 when control bit 3 = 1. `sdo` presents the word most significant bit first and is stable at each leading clock edge.
- R3: The received word, which is `sdi` sampled at the leading edges with the first bit as MSB, is returned by a read of address 2. In 8-bit mode the upper byte reads 0.
- R4: If the receive word is still unread when a transfer completes, status bit 6 sets. The new word is discarded, and the next read of address 2 returns the older word.
- R5: While status bit 6 is set and the receive word is unread, no transfer runs and a pending transmit word stays pending. After address 2 is read, the pending word is sent.
- R6: Status bit 1 sets on a write to address 2 and clears when the word moves into the shift register. Status bit 0 sets when a word is stored and clears when address 2 is read.
- R7: Each completion sets status bit 8. `irq` is status bit 8 gated by control bit 7. Writing 0 to status bit 8 clears it.
- R8: In master mode each half period of `sck_o` lasts 2^P system clocks, where P is control bits [2:0].
- R9: `sck_o` idles at the level in control bit 4. The leading edge is the edge that leaves the idle level.
- R10: In slave mode (control bit 5 = 0) the block shifts on `sck_i` edges only while `ss_n_i` is low. `sck_i` and `ss_n_i` are synchronized first. Clock edges while `ss_n_i` is high are ignored.
- R11: Clearing status bit 15 aborts a transfer. The busy bit drops, `sck_o` returns to its idle level, and the bit count restarts.
- R12: Writing 0 to status bit 6 clears the overflow flag, and writing 1 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read of address 2 consumes the receive word) |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | High when the block drives the serial clock |
| sck_i | input | 1 | Serial clock from an external master |
| ss_n_i | input | 1 | Active-low slave select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never both high. They also assume that in slave mode `sck_i` holds each level for at least three system clocks, so the synchronizer sees every edge. `sdi` is assumed stable around each leading edge. The bench issues one bus access at a time. It holds every slave clock level for eight system clocks and changes `sdi` only midway through the idle half of the clock. In master mode, `sdi` loops back from `sdo`, either straight or inverted, so the data stays stable across each sampling edge.

// File: rtl/spi_dbuf_ctrl.sv
module spi_dbuf_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq,
  output logic        sck_o,
  output logic        sck_oe,
  input  logic        sck_i,
  input  logic        ss_n_i,
  input  logic        sdi,
  output logic        sdo
);
  localparam int PRESC_W = 3;
  localparam int DIV_W = 1 << PRESC_W;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;

  logic [7:0] ctrl;
  logic en, ovf, irqf, rx_full, tx_full, busy, phase, samp;
  logic [15:0] sr, txbuf, rxbuf;
  logic [3:0] bit_cnt;
  logic [DIV_W-1:0] div_cnt, div_lim;
  logic sck_m, sck_s, ss_m, ss_s, lvl_q;

  wire master = ctrl[5];
  wire wide   = ctrl[3];
  wire cpol   = ctrl[4];
  wire lock   = ovf & rx_full;
  wire wr_ctrl = bus_wr && bus_addr == A_CTRL;
  wire wr_stat = bus_wr && bus_addr == A_STAT;
  wire wr_data = bus_wr && bus_addr == A_DATA;
  wire rd_data = bus_rd && bus_addr == A_DATA;

  assign div_lim = (DIV_W'(1) << ctrl[PRESC_W-1:0]) - DIV_W'(1);
  wire tick  = busy && div_cnt == div_lim;
  wire lvl   = sck_s ^ cpol;
  wire act   = en & ~lock & (master ? busy : ~ss_s);
  wire lead  = act & (master ? (tick & ~phase) : (lvl & ~lvl_q));
  wire trail = act & (master ? (tick & phase) : (~lvl & lvl_q));
  wire last  = bit_cnt == (wide ? 4'd15 : 4'd7);
  wire done  = trail & last;
  wire [15:0] sr_nx = {sr[14:0], samp};
  wire load  = en & ~lock & tx_full & (master ? ~busy : (bit_cnt == 4'd0 && !trail));

  assign irq    = irqf & ctrl[7];
  assign sck_o  = phase ^ cpol;
  assign sck_oe = en & master;
  assign sdo    = wide ? sr[15] : sr[7];

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {8'h00, ctrl};
      A_STAT:  bus_rdata = {en, 6'd0, irqf, 1'b0, ovf, 3'd0, busy, tx_full, rx_full};
      A_DATA:  bus_rdata = rxbuf;
      default: bus_rdata = 16'h0000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; en <= 1'b0; ovf <= 1'b0; irqf <= 1'b0;
      rx_full <= 1'b0; tx_full <= 1'b0; busy <= 1'b0; phase <= 1'b0; samp <= 1'b0;
      sr <= '0; txbuf <= '0; rxbuf <= '0; bit_cnt <= '0; div_cnt <= '0;
      sck_m <= 1'b0; sck_s <= 1'b0; ss_m <= 1'b1; ss_s <= 1'b1; lvl_q <= 1'b0;
    end else begin
      sck_m <= sck_i; sck_s <= sck_m;
      ss_m  <= ss_n_i; ss_s <= ss_m;
      lvl_q <= lvl;
      if (wr_ctrl) ctrl <= bus_wdata[7:0];
      if (wr_stat) begin
        en <= bus_wdata[15];
        if (!bus_wdata[6]) ovf <= 1'b0;
        if (!bus_wdata[8]) irqf <= 1'b0;
      end
      if (rd_data) rx_full <= 1'b0;
      if (load) begin
        sr <= txbuf;
        tx_full <= 1'b0;
        if (master) busy <= 1'b1;
      end
      if (wr_data) begin
        txbuf <= bus_wdata;
        tx_full <= 1'b1;
      end
      if (lead) samp <= sdi;
      if (trail) begin
        sr <= sr_nx;
        bit_cnt <= last ? 4'd0 : bit_cnt + 4'd1;
      end
      if (done) begin
        irqf <= 1'b1;
        busy <= 1'b0;
        if (rx_full && !rd_data) ovf <= 1'b1;
        else begin
          rxbuf <= wide ? sr_nx : {8'h00, sr_nx[7:0]};
          rx_full <= 1'b1;
        end
      end
      if (busy) begin
        if (tick) begin
          div_cnt <= '0;
          phase <= ~phase;
        end else div_cnt <= div_cnt + DIV_W'(1);
      end else begin
        div_cnt <= '0;
        phase <= 1'b0;
      end
      if (!master && ss_s) bit_cnt <= 4'd0;
      if (!en) begin
        busy <= 1'b0; phase <= 1'b0; bit_cnt <= 4'd0; div_cnt <= '0;
      end
    end
  end

  a_r4_drop_new_word: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rx_full && !rd_data) |=> ($stable(rxbuf) && ovf));
  a_r5_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && en) |=> ($stable(sr) && $stable(bit_cnt) && !busy));
  a_r6_write_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> tx_full);
  a_r7_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> irqf);
  a_r11_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!busy && !phase && bit_cnt == 4'd0));
  a_r2_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (load && master) |=> busy);
endmodule

// File: tb/spi_dbuf_ctrl_tb.sv
module spi_dbuf_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'h0, bus_rdata;
  logic irq, sck_o, sck_oe, sdo, sdi;
  logic sck_i = 1'b0, ss_n_i = 1'b1, drv_sdi = 1'b0;
  logic use_loop = 1'b1, inv = 1'b0, cpol_tb = 1'b0, sck_prev = 1'b0;
  logic [15:0] cap = 16'h0;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;
  assign sdi = use_loop ? (sdo ^ inv) : drv_sdi;

  spi_dbuf_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sck_o(sck_o), .sck_oe(sck_oe),
    .sck_i(sck_i), .ss_n_i(ss_n_i), .sdi(sdi), .sdo(sdo));

  always @(negedge clk) begin
    if ((sck_o ^ cpol_tb) && !sck_prev) cap <= {cap[14:0], sdo};
    sck_prev <= sck_o ^ cpol_tb;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wait_rx();
    logic [15:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd(2'd1, s);
      if (s[0]) return;
    end
    chk(1'b0, "R2 transfer never completed", 16'h0, 16'h1);
  endtask

  task automatic master_xfer(input logic [15:0] tx, input bit wide, input logic [2:0] pre, input bit ie);
    logic [15:0] got, s, m;
    m = wide ? 16'hFFFF : 16'h00FF;
    wr(2'd0, {8'h00, ie, 1'b0, 1'b1, cpol_tb, wide, pre});
    wr(2'd1, 16'h8000);
    cap = 16'h0;
    wr(2'd2, tx);
    wait_rx();
    chk(irq == ie, "R7 irq gating", {15'd0, irq}, {15'd0, ie});
    rd(2'd1, s);
    chk(s[8] == 1'b1, "R7 flag set", s, s | 16'h0100);
    rd(2'd2, got);
    chk(got == ((inv ? ~tx : tx) & m), "R3 received word", got, (inv ? ~tx : tx) & m);
    chk((cap & m) == (tx & m), "R2 sdo order", cap & m, tx & m);
  endtask

  task automatic slave_xfer(input logic [15:0] tx, input logic [15:0] rxw, input bit wide);
    logic [15:0] got, seen;
    int n;
    n = wide ? 16 : 8;
    seen = 16'h0;
    use_loop = 1'b0;
    wr(2'd0, {8'h00, 4'b0000, wide, 3'b000});
    wr(2'd1, 16'h8000);
    wr(2'd2, tx);
    repeat (6) @(negedge clk);
    ss_n_i = 1'b0;
    repeat (8) @(negedge clk);
    for (int b = n - 1; b >= 0; b--) begin
      drv_sdi = rxw[b];
      repeat (8) @(negedge clk);
      seen = {seen[14:0], sdo};
      sck_i = 1'b1;
      repeat (8) @(negedge clk);
      sck_i = 1'b0;
      repeat (8) @(negedge clk);
    end
    ss_n_i = 1'b1;
    repeat (8) @(negedge clk);
    rd(2'd2, got);
    chk(got == (wide ? rxw : {8'h00, rxw[7:0]}), "R10 slave receive", got, wide ? rxw : {8'h00, rxw[7:0]});
    chk(seen == (wide ? tx : {8'h00, tx[7:0]}), "R10 slave sdo", seen, wide ? tx : {8'h00, tx[7:0]});
    use_loop = 1'b1;
  endtask

  initial begin
    logic [15:0] s, d;
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, d); chk(d == 16'h0, "R1 control reset", d, 16'h0);
    rd(2'd1, s); chk(s == 16'h0, "R1 status reset", s, 16'h0);
    chk({irq, sck_o, sck_oe} == 3'b000, "R1 outputs reset", {13'd0, irq, sck_o, sck_oe}, 16'h0);

    // R6 transmit full while disabled, then handoff
    wr(2'd0, 16'h0020);
    wr(2'd2, 16'h00A5);
    rd(2'd1, s); chk(s[2:0] == 3'b010, "R6 tx full held while disabled", s, 16'h0002);
    wr(2'd1, 16'h8000);
    wait_rx();
    rd(2'd1, s); chk(s[1:0] == 2'b01, "R6 tx cleared rx set", s, 16'h8001);
    rd(2'd2, d); chk(d == 16'h00A5, "R3 first word", d, 16'h00A5);
    rd(2'd1, s); chk(s[0] == 1'b0, "R6 rx cleared by read", s, 16'h0);

    // R2/R3 sweeps, 8-bit and 16-bit
    for (int i = 0; i < 16; i++) begin
      inv = i[0];
      master_xfer(16'(i * 17) ^ 16'hA500, 1'b0, 3'(i % 2), i[1]);
    end
    for (int i = 0; i < 12; i++) begin
      inv = i[0];
      master_xfer(16'h8001 ^ 16'(i * 16'h0F0F), 1'b1, 3'd0, 1'b1);
    end
    inv = 1'b0;

    // R7 clear flag
    wr(2'd1, 16'h8000);
    chk(irq == 1'b0, "R7 flag cleared by write", {15'd0, irq}, 16'h0);

    // R8 divider
    wr(2'd0, 16'h0022);
    wr(2'd1, 16'h8000);
    wr(2'd2, 16'h0055);
    while (!sck_o) @(negedge clk);
    while (sck_o) @(negedge clk);
    cnt = 0;
    while (!sck_o) begin @(negedge clk); cnt++; end
    while (sck_o) begin @(negedge clk); cnt++; end
    chk(cnt == 8, "R8 sck period for P=2", 16'(cnt), 16'd8);
    wait_rx(); rd(2'd2, d);

    // R9 clock idle level
    cpol_tb = 1'b1;
    wr(2'd0, 16'h0030);
    wr(2'd1, 16'h8000);
    chk(sck_o == 1'b1, "R9 idle high", {15'd0, sck_o}, 16'h1);
    master_xfer(16'h00C6, 1'b0, 3'd1, 1'b0);
    chk(sck_o == 1'b1, "R9 idle after transfer", {15'd0, sck_o}, 16'h1);
    cpol_tb = 1'b0;

    // R11 disable aborts
    wr(2'd0, 16'h002F);
    wr(2'd1, 16'h8000);
    wr(2'd2, 16'h1234);
    repeat (200) @(negedge clk);
    rd(2'd1, s); chk(s[2] == 1'b1, "R11 busy before abort", s, s | 16'h4);
    wr(2'd1, 16'h0000);
    rd(2'd1, s); chk(s[2] == 1'b0 && s[0] == 1'b0, "R11 busy cleared", s, 16'h0);
    chk(sck_o == 1'b0, "R11 sck idle", {15'd0, sck_o}, 16'h0);

    // R4 R5 R12 overflow and lockout
    wr(2'd0, 16'h0020);
    wr(2'd1, 16'h8000);
    wr(2'd2, 16'h003C);
    wait_rx();
    wr(2'd2, 16'h00C3);
    repeat (60) @(negedge clk);
    rd(2'd1, s); chk(s[6] && s[0], "R4 overflow set", s, 16'h8141);
    wr(2'd2, 16'h0099);
    repeat (60) @(negedge clk);
    rd(2'd1, s); chk(s[1] && !s[2], "R5 locked, word pending", s, 16'h8143);
    rd(2'd2, d); chk(d == 16'h003C, "R4 older word kept", d, 16'h003C);
    wait_rx();
    rd(2'd2, d); chk(d == 16'h0099, "R5 pending word sent after read", d, 16'h0099);
    rd(2'd1, s); chk(s[6] == 1'b1, "R12 overflow sticky", s, s | 16'h40);
    wr(2'd1, 16'h8040);
    rd(2'd1, s); chk(s[6] == 1'b1, "R12 writing one keeps", s, s | 16'h40);
    wr(2'd1, 16'h8000);
    rd(2'd1, s); chk(s[6] == 1'b0, "R12 writing zero clears", s, s & ~16'h40);

    // R10 slave mode
    slave_xfer(16'h00B4, 16'h0069, 1'b0);
    slave_xfer(16'h0017, 16'h00E2, 1'b0);
    slave_xfer(16'hC35A, 16'h1E87, 1'b1);
    wr(2'd0, 16'h0000);
    for (int k = 0; k < 8; k++) begin
      repeat (8) @(negedge clk); sck_i = 1'b1;
      repeat (8) @(negedge clk); sck_i = 1'b0;
    end
    repeat (8) @(negedge clk);
    rd(2'd1, s); chk(s[0] == 1'b0, "R10 deselected edges ignored", s, s & ~16'h1);
    chk(sck_oe == 1'b0, "R10 clock not driven in slave", {15'd0, sck_oe}, 16'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule